// File: doc/BRIEF.md
# Dual Cycle Performance Counters

This block holds one 32-bit control word and two 32-bit cycle counters for a processor's debug and profiling logic. Each counter adds one on every clock edge while the control word, under a fixed per-counter mask, equals a fixed per-counter pattern. Both patterns require the top bit of the control word, which acts as a shared global enable, plus a one-hot code in a counter-specific event-select field. The only event source modelled is elapsed clock cycles.

Software reaches the three registers through a 6-bit selector, a write strobe and a write data bus. The read data is a combinational function of the selector and the current register state. A write takes effect at the next rising clock edge. In the cycle that carries a control write, both counters still advance under the old control word, so cycles counted before the change are kept. In the cycle that carries a counter write, the loaded value replaces that cycle's increment.

Top module: `perf_cnt_unit`

## Requirements
- R1: After the asynchronous active-low reset, the control word and both counters are zero, so every selector reads zero.
- R2: Counter 0 adds 1 at each rising edge where (control & 0x800003E0) == 0x80000020. At every other edge it holds, unless it is written.
- R3: Counter 1 adds 1 at each rising edge where (control & 0x800F8000) == 0x80008000. At every other edge it holds, unless it is written.
- R4: Selector value 0 addresses the control word, 1 addresses counter 0 and 3 addresses counter 1. rd_data_o shows the addressed register's current value in the same cycle.
- R5: Any other selector value reads zero. A write to such a value changes none of the three registers.
- R6: A control write is stored at the next edge. At that same edge each counter advances according to the control value held before the write. The new value governs counting from the following edge on.
- R7: A counter write loads wr_data_i at the next edge in place of that edge's increment. Counting then continues from the loaded value.
- R8: The counters wrap from 0xFFFFFFFF to 0x00000000 and keep counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 6 | Register selector (0 control, 1 counter 0, 3 counter 1) |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of the selected register, combinational |

## Verification
Read data is due in the same cycle as the selector. Writes and increments reach the read port exactly one rising edge after the cycle that carries them. The bench drives inputs on the falling edge and compares rd_data_o one nanosecond later against a behavioural model. The model advances only at the rising edge, using the inputs held during the cycle that just ended. Because the model uses the pre-edge control word for counting and lets writes override increments, the timing rules R6 and R7 are checked on every clock.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  localparam int unsigned CW      = 32;
  localparam int unsigned SW      = 6;
  localparam int unsigned NUM_CNT = 2;

  localparam logic [SW-1:0] SEL_CTRL = 6'd0;
  localparam logic [SW-1:0] CNT_SEL [NUM_CNT] = '{6'd1, 6'd3};

  // compare mask and pattern per counter; bit 31 is the shared enable
  localparam logic [CW-1:0] EV_MASK [NUM_CNT] = '{32'h8000_03E0, 32'h800F_8000};
  localparam logic [CW-1:0] EV_PAT  [NUM_CNT] = '{32'h8000_0020, 32'h8000_8000};
endpackage

// File: rtl/perf_ctrl_reg.sv
module perf_ctrl_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_o <= '0;
    else if (wr_i) ctrl_o <= wdata_i;
  end

  p_ctrl_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ctrl_o == $past(wdata_i));
  p_ctrl_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_o));
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int unsigned   W       = 32,
  parameter logic [W-1:0]  MASK    = '0,
  parameter logic [W-1:0]  PATTERN = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ctrl_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o
);
  logic run;
  assign run = (ctrl_i & MASK) == PATTERN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (wr_i) cnt_o <= wdata_i;   // write beats count
    else if (run)  cnt_o <= cnt_o + 1'b1;
  end

  // R2 and R3 per instance
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wr_i) |=> cnt_o == $past(cnt_o) + 1'b1);
  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_i) |=> $stable(cnt_o));
  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_o == $past(wdata_i));
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wr_i && cnt_o == '1) |=> cnt_o == '0);
endmodule

// File: rtl/perf_rd_mux.sv
module perf_rd_mux #(
  parameter int unsigned W = 32,
  parameter int unsigned S = 6,
  parameter int unsigned N = 2
) (
  input  logic [S-1:0]        sel_i,
  input  logic [W-1:0]        ctrl_i,
  input  logic [N-1:0][W-1:0] cnt_i,
  output logic [W-1:0]        rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (sel_i == perf_cnt_pkg::SEL_CTRL) rdata_o = ctrl_i;
    for (int i = 0; i < N; i++)
      if (sel_i == perf_cnt_pkg::CNT_SEL[i]) rdata_o = cnt_i[i];
  end
endmodule

// File: rtl/perf_cnt_unit.sv
module perf_cnt_unit
  import perf_cnt_pkg::*;
#(
  parameter int unsigned DATA_W = CW,
  parameter int unsigned SEL_W  = SW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned N = NUM_CNT;

  logic [DATA_W-1:0]        ctrl_q;
  logic [N-1:0][DATA_W-1:0] cnt_q;
  logic                     wr_ctrl;
  logic [N-1:0]             wr_cnt;

  assign wr_ctrl = wr_en_i && (sel_i == SEL_CTRL);

  perf_ctrl_reg #(.W(DATA_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_ctrl),
    .wdata_i(wr_data_i), .ctrl_o(ctrl_q)
  );

  for (genvar g = 0; g < N; g++) begin : g_cnt
    assign wr_cnt[g] = wr_en_i && (sel_i == CNT_SEL[g]);
    perf_counter #(
      .W(DATA_W), .MASK(EV_MASK[g]), .PATTERN(EV_PAT[g])
    ) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_q),
      .wr_i(wr_cnt[g]), .wdata_i(wr_data_i), .cnt_o(cnt_q[g])
    );
  end

  perf_rd_mux #(.W(DATA_W), .S(SEL_W), .N(N)) u_mux (
    .sel_i(sel_i), .ctrl_i(ctrl_q), .cnt_i(cnt_q), .rdata_o(rd_data_o)
  );

  p_unused_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != SEL_CTRL && sel_i != CNT_SEL[0] && sel_i != CNT_SEL[1])
      |-> rd_data_o == '0);
  p_one_target_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_ctrl, wr_cnt}));
endmodule

// File: tb/tb_perf_cnt_unit.sv
`timescale 1ns/1ps
module tb_perf_cnt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  sel = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [31:0] m_ctrl = '0, m_c0 = '0, m_c1 = '0;

  perf_cnt_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel),
    .wr_en_i(wr), .wr_data_i(wdata), .rd_data_o(rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] model_read(input logic [5:0] s);
    case (s)
      6'd0: return m_ctrl;
      6'd1: return m_c0;
      6'd3: return m_c1;
      default: return 32'h0;
    endcase
  endfunction

  // one cycle: drive at falling edge, check, then advance model at rising edge
  task automatic step(input logic [5:0] s, input logic w, input logic [31:0] d,
                      input string req);
    logic [31:0] exp;
    logic inc0, inc1;
    sel = s; wr = w; wdata = d;
    #1;
    exp = model_read(s);
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", req, s, rdata, exp);
    end
    @(posedge clk);
    inc0 = (m_ctrl & 32'h8000_03E0) == 32'h8000_0020;
    inc1 = (m_ctrl & 32'h800F_8000) == 32'h8000_8000;
    if (w && s == 6'd1) m_c0 = d; else if (inc0) m_c0 = m_c0 + 32'd1;
    if (w && s == 6'd3) m_c1 = d; else if (inc1) m_c1 = m_c1 + 32'd1;
    if (w && s == 6'd0) m_ctrl = d;
    @(negedge clk);
  endtask

  task automatic reads(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step(6'd1, 1'b0, '0, req);
      step(6'd3, 1'b0, '0, req);
      step(6'd0, 1'b0, '0, req);
    end
  endtask

  initial begin
    while (cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values on every selector
    for (int s = 0; s < 8; s++) step(6'(s), 1'b0, '0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    reads(2, "R1");

    // R2: counter 0 only
    step(6'd0, 1'b1, 32'h8000_0020, "R2");
    reads(4, "R2");
    // R3: counter 1 only
    step(6'd0, 1'b1, 32'h8000_8000, "R3");
    reads(4, "R3");
    // R2 R3: both, with unrelated bits set
    step(6'd0, 1'b1, 32'h8F00_8020 & 32'h800F_FFFF | 32'h0000_000F, "R3");
    reads(4, "R2");
    // global enable clear: neither counts
    step(6'd0, 1'b1, 32'h0000_8020, "R2");
    reads(3, "R2");
    // wrong event codes: neither counts
    step(6'd0, 1'b1, 32'h8001_0040, "R3");
    reads(3, "R3");

    // R6: control change back to back, each cycle counts under old value
    step(6'd0, 1'b1, 32'h8000_8020, "R6");
    step(6'd0, 1'b1, 32'h0000_0000, "R6");
    step(6'd1, 1'b0, '0, "R6");
    step(6'd3, 1'b0, '0, "R6");
    step(6'd0, 1'b1, 32'h8000_8020, "R6");
    reads(2, "R6");

    // R7: counter writes while counting
    step(6'd1, 1'b1, 32'h1234_5678, "R7");
    step(6'd1, 1'b0, '0, "R7");
    step(6'd3, 1'b1, 32'h0000_0100, "R7");
    step(6'd3, 1'b1, 32'h0000_0200, "R7");
    reads(2, "R7");

    // R8: wrap on both counters
    step(6'd1, 1'b1, 32'hFFFF_FFFE, "R8");
    step(6'd3, 1'b1, 32'hFFFF_FFFF, "R8");
    reads(3, "R8");

    // R4 / R5: unused selectors read zero and ignore writes
    for (int s = 0; s < 64; s++)
      if (s != 0 && s != 1 && s != 3) step(6'(s), 1'b1, 32'hDEAD_BEEF, "R5");
    reads(2, "R5");
    step(6'd0, 1'b0, '0, "R4");
    step(6'd1, 1'b0, '0, "R4");
    step(6'd3, 1'b0, '0, "R4");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule